// File: doc/BRIEF.md
# Variable-Span Fully Associative Translation Buffer

This block holds a small set of address translations. Each entry maps a naturally aligned virtual region of 4^k base pages onto a physical region, together with a packed set of attribute fields. The slots come in two groups. The low `NPIN` slots are pinned: only the dedicated slot-write and slot-purge commands touch them. The remaining slots are ordinary: inserts fill them, range purges and purge-all clear them, and a round-robin pointer picks a victim when all of them are in use.

All operations arrive on one command port with a valid/ready handshake. Each accepted command yields exactly one single-cycle response carrying a status, a slot index, a physical address and the attribute word. A lookup compares the address against every slot in the same cycle, and the lowest matching index wins. An insert takes two cycles. In the first, it clears the ordinary entries that its new range overlaps. In the second, it picks a slot from the cleaned table and writes the entry there. While the second cycle runs, `cmd_ready` is low.

Top module: `vsize_tlb`

## Requirements
- R1: After reset every slot is invalid, the round-robin pointer is at slot `NPIN`, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: An insert takes its size code k from `cmd_w1[3:0]`. It covers 2^(PAGE_BITS+2k) bytes starting at `cmd_addr` aligned down to that size. Lookups inside the range hit and lookups outside it miss.
- R3: The physical base is `cmd_w1` shifted left by PAGE_BITS-5, with the bits below the entry size cleared, then sign-extended from bit PA_W-1 to 64 bits.
- R4: `rsp_attr` packs fields of `cmd_w2` as follows: [41] = w2[61], [40] = w2[60], [39] = w2[59], [38:36] = w2[58:56], [35:34] = w2[55:54], [33:32] = w2[53:52], [31] = w2[51], [30:0] = w2[31:1].
- R5: A lookup hit (op 0) returns status 0. It gives the lowest matching slot index and the entry's physical base plus (address - entry start).
- R6: A lookup miss returns status 1 when `cmd_fetch` is 1 and status 2 when it is 0. Index, address and attributes are 0.
- R7: Before an insert (op 1) writes its entry, every valid ordinary entry whose range overlaps the new range is invalidated. Pinned entries are left untouched.
- R8: An insert uses the lowest-index free ordinary slot. If no ordinary slot is free, it uses the round-robin pointer (treated as `NPIN` when it is below `NPIN` or at/above `NSLOT`) and then advances the pointer by one. The response gives status 0 and the chosen index.
- R9: A range purge (op 2) takes start = `cmd_addr` with the low PAGE_BITS bits cleared, and code = `cmd_addr[3:0]`. It invalidates every ordinary entry that overlaps start through start + 2^(PAGE_BITS+2*code) - 1. It returns status 0.
- R10: Purge-all (op 3) invalidates every ordinary slot, sets the pointer back to `NPIN`, keeps every pinned slot as it was, and returns status 0.
- R11: A pinned write (op 4) loads slot `cmd_slot` in the same way as an insert, but forces attribute bit [41] to 0 and bit [40] to 1. A pinned purge (op 5) clears that slot. Either op with `cmd_slot` >= `NPIN`, and any op 6 or 7, changes nothing and returns status 3.
- R12: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. For an insert, `cmd_ready` is 0 for the cycle after acceptance, and `rsp_valid` rises one cycle after that. For every other op, `rsp_valid` is 1 for the single cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | 0 lookup, 1 insert, 2 range purge, 3 purge-all, 4 pinned write, 5 pinned purge |
| cmd_fetch | input | 1 | Lookup is an instruction fetch (selects the miss code) |
| cmd_addr | input | 64 | Virtual address, or purge start with size code in [3:0] |
| cmd_w1 | input | 64 | First entry word: physical frame and size code |
| cmd_w2 | input | 64 | Second entry word: attribute fields |
| cmd_slot | input | $clog2(NSLOT) | Target slot for pinned write or purge |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 2 | 0 ok, 1 fetch miss, 2 data miss, 3 invalid argument |
| rsp_index | output | $clog2(NSLOT) | Hit slot or slot written |
| rsp_pa | output | 64 | Translated physical address |
| rsp_attr | output | 42 | Attribute fields of the hit or written entry |

## Verification
The properties assume that `cmd_op`, `cmd_slot` and `cmd_fetch` hold steady in the cycle where a command is accepted. They also assume that no command is treated as taken while `cmd_ready` is low. The bench holds every command input from one falling edge to the next, waits at a falling edge until `cmd_ready` is high before raising `cmd_valid`, and drops `cmd_valid` after a single cycle. The pinned-slot properties rely on `NPIN` being at least 1 and below `NSLOT`, which holds for the default parameters used in the run.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_INSERT    = 3'd1,
        OP_PURGE     = 3'd2,
        OP_PURGE_ALL = 3'd3,
        OP_PIN_WRITE = 3'd4,
        OP_PIN_PURGE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_IMISS  = 2'd1,
        ST_DMISS  = 2'd2,
        ST_BADARG = 2'd3
    } status_e;

    // 42-bit attribute word, most significant field first
    typedef struct packed {
        logic        trap;
        logic        dirty;
        logic        brk;
        logic [2:0]  acc_type;
        logic [1:0]  lvl_hi;
        logic [1:0]  lvl_lo;
        logic        uncached;
        logic [30:0] prot_id;
    } attr_t;

    typedef struct packed {
        logic        valid;
        logic [63:0] first;
        logic [63:0] last;
        logic [63:0] pa;
        attr_t       attr;
    } entry_t;

    function automatic attr_t attr_from_word(input logic [63:0] w);
        attr_t a;
        a.trap     = w[61];
        a.dirty    = w[60];
        a.brk      = w[59];
        a.acc_type = w[58:56];
        a.lvl_hi   = w[55:54];
        a.lvl_lo   = w[53:52];
        a.uncached = w[51];
        a.prot_id  = w[31:1];
        return a;
    endfunction

endpackage

// File: rtl/vtlb_span.sv
// Turns a base address and a 4-bit size code into an inclusive range.
module vtlb_span #(
    parameter int PAGE_BITS  = 12,
    parameter bit ALIGN_SPAN = 1'b1
) (
    input  logic [63:0] base,
    input  logic [3:0]  code,
    output logic [63:0] first,
    output logic [63:0] last
);
    logic [63:0] span;

    assign span = 64'd1 << (PAGE_BITS + 2 * int'(code));

    generate
        if (ALIGN_SPAN) begin : g_size_align
            assign first = base & ~(span - 64'd1);
        end else begin : g_page_align
            assign first = base & ~((64'd1 << PAGE_BITS) - 64'd1);
        end
    endgenerate

    assign last = first + span - 64'd1;
endmodule

// File: rtl/vtlb_match.sv
// Range comparison against every slot plus lowest-index priority pick.
module vtlb_match #(
    parameter int NSLOT = 16,
    parameter int IDX_W = $clog2(NSLOT)
) (
    input  vtlb_pkg::entry_t ents [NSLOT],
    input  logic [63:0]      q_first,
    input  logic [63:0]      q_last,
    output logic [NSLOT-1:0] ovl,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
            assign ovl[i] = ents[i].valid
                         && (ents[i].first <= q_last)
                         && (q_first <= ents[i].last);
        end
    endgenerate

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (ovl[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vtlb_alloc.sv
// Victim choice among ordinary slots: lowest free, else round robin.
module vtlb_alloc #(
    parameter int NSLOT = 16,
    parameter int NPIN  = 4,
    parameter int IDX_W = $clog2(NSLOT),
    parameter int CNT_W = $clog2(NSLOT + 1)
) (
    input  logic [NSLOT-1:0] valid_vec,
    input  logic [CNT_W-1:0] rr_q,
    output logic [IDX_W-1:0] victim,
    output logic [CNT_W-1:0] rr_next
);
    logic             found;
    logic [CNT_W-1:0] rr_use;

    always_comb begin
        found   = 1'b0;
        victim  = '0;
        rr_use  = rr_q;
        rr_next = rr_q;
        for (int i = NSLOT - 1; i >= NPIN; i--) begin
            if (!valid_vec[i]) begin
                found  = 1'b1;
                victim = IDX_W'(i);
            end
        end
        if (!found) begin
            if (rr_q < CNT_W'(NPIN) || rr_q >= CNT_W'(NSLOT)) begin
                rr_use = CNT_W'(NPIN);
            end
            victim  = rr_use[IDX_W-1:0];
            rr_next = rr_use + CNT_W'(1);
        end
    end
endmodule

// File: rtl/vsize_tlb.sv
module vsize_tlb #(
    parameter int NSLOT     = 16,
    parameter int NPIN      = 4,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 40,
    localparam int IDX_W    = $clog2(NSLOT),
    localparam int CNT_W    = $clog2(NSLOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_fetch,
    input  logic [63:0]      cmd_addr,
    input  logic [63:0]      cmd_w1,
    input  logic [63:0]      cmd_w2,
    input  logic [IDX_W-1:0] cmd_slot,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [IDX_W-1:0] rsp_index,
    output logic [63:0]      rsp_pa,
    output logic [41:0]      rsp_attr
);
    import vtlb_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] rr;
        logic [63:0]      p_first;
        logic [63:0]      p_last;
        logic [63:0]      p_pa;
        attr_t            p_attr;
        logic             rsp_valid;
        status_e          rsp_status;
        logic [IDX_W-1:0] rsp_index;
        logic [63:0]      rsp_pa;
        attr_t            rsp_attr;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    entry_t ent_d [NSLOT];
    entry_t ent_q [NSLOT];

    logic [NSLOT-1:0] valid_vec;
    logic [63:0]      ins_first, ins_last, prg_first, prg_last;
    logic [63:0]      rng_first, rng_last;
    logic [NSLOT-1:0] lk_vec, rng_vec;
    logic             lk_any, rng_any;
    logic [IDX_W-1:0] lk_idx, rng_idx;
    logic [IDX_W-1:0] victim;
    logic [CNT_W-1:0] rr_next;
    op_e              op;
    logic             slot_ok;
    attr_t            pin_attr;

    function automatic logic [63:0] form_pa(input logic [63:0] w1);
        logic [63:0] raw;
        logic [63:0] keep;
        raw  = w1 << (PAGE_BITS - 5);
        raw  = raw & ~((64'd1 << (PAGE_BITS + 2 * int'(w1[3:0]))) - 64'd1);
        keep = (64'd1 << PA_W) - 64'd1;
        return raw[PA_W-1] ? (raw | ~keep) : (raw & keep);
    endfunction

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_vld
            assign valid_vec[i] = ent_q[i].valid;
        end
    endgenerate

    vtlb_span #(.PAGE_BITS(PAGE_BITS), .ALIGN_SPAN(1'b1)) u_ins_span (
        .base(cmd_addr), .code(cmd_w1[3:0]), .first(ins_first), .last(ins_last)
    );

    vtlb_span #(.PAGE_BITS(PAGE_BITS), .ALIGN_SPAN(1'b0)) u_prg_span (
        .base(cmd_addr), .code(cmd_addr[3:0]), .first(prg_first), .last(prg_last)
    );

    assign op        = op_e'(cmd_op);
    assign rng_first = (op == OP_INSERT) ? ins_first : prg_first;
    assign rng_last  = (op == OP_INSERT) ? ins_last  : prg_last;
    assign slot_ok   = (int'(cmd_slot) < NPIN);

    always_comb begin
        pin_attr       = attr_from_word(cmd_w2);
        pin_attr.trap  = 1'b0;
        pin_attr.dirty = 1'b1;
    end

    vtlb_match #(.NSLOT(NSLOT)) u_lk_match (
        .ents(ent_q), .q_first(cmd_addr), .q_last(cmd_addr),
        .ovl(lk_vec), .any(lk_any), .idx(lk_idx)
    );

    vtlb_match #(.NSLOT(NSLOT)) u_rng_match (
        .ents(ent_q), .q_first(rng_first), .q_last(rng_last),
        .ovl(rng_vec), .any(rng_any), .idx(rng_idx)
    );

    vtlb_alloc #(.NSLOT(NSLOT), .NPIN(NPIN)) u_alloc (
        .valid_vec(valid_vec), .rr_q(ctl_q.rr), .victim(victim), .rr_next(rr_next)
    );

    always_comb begin
        ent_d           = ent_q;
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        if (ctl_q.busy) begin
            // second insert cycle: overlaps are gone, place the entry
            ent_d[victim].valid = 1'b1;
            ent_d[victim].first = ctl_q.p_first;
            ent_d[victim].last  = ctl_q.p_last;
            ent_d[victim].pa    = ctl_q.p_pa;
            ent_d[victim].attr  = ctl_q.p_attr;
            ctl_d.rr            = rr_next;
            ctl_d.busy          = 1'b0;
            ctl_d.rsp_valid     = 1'b1;
            ctl_d.rsp_status    = ST_OK;
            ctl_d.rsp_index     = victim;
            ctl_d.rsp_pa        = ctl_q.p_pa;
            ctl_d.rsp_attr      = ctl_q.p_attr;
        end else if (cmd_valid) begin
            ctl_d.rsp_valid  = 1'b1;
            ctl_d.rsp_status = ST_OK;
            ctl_d.rsp_index  = '0;
            ctl_d.rsp_pa     = '0;
            ctl_d.rsp_attr   = '0;
            case (op)
                OP_LOOKUP: begin
                    if (lk_any) begin
                        ctl_d.rsp_index = lk_idx;
                        ctl_d.rsp_pa    = ent_q[lk_idx].pa + (cmd_addr - ent_q[lk_idx].first);
                        ctl_d.rsp_attr  = ent_q[lk_idx].attr;
                    end else begin
                        ctl_d.rsp_status = cmd_fetch ? ST_IMISS : ST_DMISS;
                    end
                end
                OP_INSERT, OP_PURGE: begin
                    for (int i = NPIN; i < NSLOT; i++) begin
                        if (rng_vec[i]) ent_d[i] = '0;
                    end
                    if (op == OP_INSERT) begin
                        ctl_d.busy      = 1'b1;
                        ctl_d.rsp_valid = 1'b0;
                        ctl_d.p_first   = ins_first;
                        ctl_d.p_last    = ins_last;
                        ctl_d.p_pa      = form_pa(cmd_w1);
                        ctl_d.p_attr    = attr_from_word(cmd_w2);
                    end
                end
                OP_PURGE_ALL: begin
                    for (int i = NPIN; i < NSLOT; i++) ent_d[i] = '0;
                    ctl_d.rr = CNT_W'(NPIN);
                end
                OP_PIN_WRITE: begin
                    if (slot_ok) begin
                        ent_d[cmd_slot].valid = 1'b1;
                        ent_d[cmd_slot].first = ins_first;
                        ent_d[cmd_slot].last  = ins_last;
                        ent_d[cmd_slot].pa    = form_pa(cmd_w1);
                        ent_d[cmd_slot].attr  = pin_attr;
                        ctl_d.rsp_index       = cmd_slot;
                        ctl_d.rsp_pa          = form_pa(cmd_w1);
                        ctl_d.rsp_attr        = pin_attr;
                    end else begin
                        ctl_d.rsp_status = ST_BADARG;
                    end
                end
                OP_PIN_PURGE: begin
                    if (slot_ok) begin
                        ent_d[cmd_slot] = '0;
                        ctl_d.rsp_index = cmd_slot;
                    end else begin
                        ctl_d.rsp_status = ST_BADARG;
                    end
                end
                default: ctl_d.rsp_status = ST_BADARG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) ent_q[i] <= '0;
            ctl_q    <= '0;
            ctl_q.rr <= CNT_W'(NPIN);
        end else begin
            ent_q <= ent_d;
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready  = !ctl_q.busy;
    assign rsp_valid  = ctl_q.rsp_valid;
    assign rsp_status = ctl_q.rsp_status;
    assign rsp_index  = ctl_q.rsp_index;
    assign rsp_pa     = ctl_q.rsp_pa;
    assign rsp_attr   = ctl_q.rsp_attr;

endmodule

// File: rtl/vtlb_checker.sv
module vtlb_checker #(
    parameter int NSLOT = 16,
    parameter int NPIN  = 4,
    parameter int IDX_W = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic             cmd_fetch,
    input logic [IDX_W-1:0] cmd_slot,
    input logic             rsp_valid,
    input logic [1:0]       rsp_status,
    input logic [NSLOT-1:0] valid_vec
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    assert_insert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1) |=> (!cmd_ready && !rsp_valid));

    assert_other_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op != 3'd1) |=> rsp_valid);

    assert_insert_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1) |=> ##1 (rsp_valid && rsp_status == 2'd0
                                         && (|valid_vec[NSLOT-1:NPIN])));

    assert_miss_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd0) |=>
            (rsp_status == 2'd0 || rsp_status == ($past(cmd_fetch) ? 2'd1 : 2'd2)));

    assert_badarg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cmd_op == 3'd4 || cmd_op == 3'd5) && int'(cmd_slot) >= NPIN)
            |=> (rsp_status == 2'd3 && $stable(valid_vec)));

    assert_purge_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd3) |=>
            (valid_vec[NSLOT-1:NPIN] == '0
             && valid_vec[NPIN-1:0] == $past(valid_vec[NPIN-1:0])));

endmodule

bind vsize_tlb vtlb_checker #(.NSLOT(NSLOT), .NPIN(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_fetch(cmd_fetch), .cmd_slot(cmd_slot),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .valid_vec(valid_vec)
);

// File: tb/test_vsize_tlb.sv
module test_vsize_tlb;
    localparam int N = 16;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic        cmd_fetch = 1'b0;
    logic [63:0] cmd_addr = '0, cmd_w1 = '0, cmd_w2 = '0;
    logic [3:0]  cmd_slot = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [3:0]  rsp_index;
    logic [63:0] rsp_pa;
    logic [41:0] rsp_attr;

    int    n_checks = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    bit    running = 1'b0;

    vsize_tlb i_vsize_tlb (.*);

    always #4 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic        mv [N];
    logic [63:0] mf [N], ml [N], mpa [N];
    logic [41:0] mat [N];
    int          mrr;
    bit          mbusy;
    logic [63:0] pf, pl, ppa;
    logic [41:0] pat;
    bit          e_valid;
    logic [1:0]  e_status;
    logic [3:0]  e_idx;
    logic [63:0] e_pa;
    logic [41:0] e_attr;

    function automatic logic [63:0] m_size(input logic [3:0] k);
        return 64'd4096 << (2 * int'(k));
    endfunction

    function automatic logic [63:0] m_pa(input logic [63:0] w1);
        logic [63:0] p;
        p = (w1 << 7) & ~(m_size(w1[3:0]) - 64'd1);
        return {{24{p[39]}}, p[39:0]};
    endfunction

    function automatic logic [41:0] m_attr(input logic [63:0] w);
        return {w[61], w[60], w[59], w[58:56], w[55:54], w[53:52], w[51], w[31:1]};
    endfunction

    task automatic m_clear_range(input logic [63:0] s, input logic [63:0] l);
        for (int i = P; i < N; i++)
            if (mv[i] && mf[i] <= l && s <= ml[i]) mv[i] = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
            mrr = P; mbusy = 0; e_valid = 0;
        end else begin
            e_valid = 0;
            if (mbusy) begin
                int v;
                v = -1;
                for (int i = P; i < N; i++) if (!mv[i] && v < 0) v = i;
                if (v < 0) begin
                    if (mrr < P || mrr >= N) mrr = P;
                    v = mrr; mrr = mrr + 1;
                end
                mv[v] = 1; mf[v] = pf; ml[v] = pl; mpa[v] = ppa; mat[v] = pat;
                mbusy = 0;
                e_valid = 1; e_status = 0; e_idx = 4'(v); e_pa = ppa; e_attr = pat;
            end else if (cmd_valid) begin
                logic [63:0] sz, s;
                e_valid = 1; e_status = 0; e_idx = 0; e_pa = 0; e_attr = 0;
                case (cmd_op)
                    3'd0: begin
                        int h;
                        h = -1;
                        for (int i = 0; i < N; i++)
                            if (h < 0 && mv[i] && mf[i] <= cmd_addr && cmd_addr <= ml[i]) h = i;
                        if (h >= 0) begin
                            e_idx = 4'(h); e_pa = mpa[h] + (cmd_addr - mf[h]); e_attr = mat[h];
                        end else e_status = cmd_fetch ? 2'd1 : 2'd2;
                    end
                    3'd1: begin
                        sz = m_size(cmd_w1[3:0]);
                        s  = cmd_addr & ~(sz - 64'd1);
                        m_clear_range(s, s + sz - 64'd1);
                        pf = s; pl = s + sz - 64'd1; ppa = m_pa(cmd_w1); pat = m_attr(cmd_w2);
                        mbusy = 1; e_valid = 0;
                    end
                    3'd2: begin
                        s = cmd_addr & ~64'hFFF;
                        m_clear_range(s, s + m_size(cmd_addr[3:0]) - 64'd1);
                    end
                    3'd3: begin
                        for (int i = P; i < N; i++) mv[i] = 0;
                        mrr = P;
                    end
                    3'd4, 3'd5: begin
                        if (int'(cmd_slot) >= P) e_status = 2'd3;
                        else if (cmd_op == 3'd5) begin
                            mv[cmd_slot] = 0; e_idx = cmd_slot;
                        end else begin
                            sz = m_size(cmd_w1[3:0]);
                            s  = cmd_addr & ~(sz - 64'd1);
                            mv[cmd_slot] = 1; mf[cmd_slot] = s; ml[cmd_slot] = s + sz - 64'd1;
                            mpa[cmd_slot] = m_pa(cmd_w1);
                            mat[cmd_slot] = m_attr(cmd_w2) & ~(42'd1 << 41) | (42'd1 << 40);
                            e_idx = cmd_slot; e_pa = mpa[cmd_slot]; e_attr = mat[cmd_slot];
                        end
                    end
                    default: e_status = 2'd3;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (running) begin
            check(cur_req, 64'(cmd_ready), 64'(!mbusy), "cmd_ready");
            check(cur_req, 64'(rsp_valid), 64'(e_valid), "rsp_valid");
            if (e_valid && rsp_valid) begin
                check(cur_req, 64'(rsp_status), 64'(e_status), "status");
                check(cur_req, 64'(rsp_index), 64'(e_idx), "index");
                check(cur_req, rsp_pa, e_pa, "pa");
                check(cur_req, 64'(rsp_attr), 64'(e_attr), "attr");
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [63:0] a, input logic [63:0] w1,
                        input logic [63:0] w2, input logic [3:0] slot, input logic f);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_w1 = w1; cmd_w2 = w2; cmd_slot = slot; cmd_fetch = f;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 3'd1) check("R12", 64'(cmd_ready), 64'd0, "ready low after insert");
        @(negedge clk);
    endtask

    task automatic look(input logic [63:0] a, input logic f);
        send(3'd0, a, 0, 0, 0, f);
    endtask

    task automatic ins(input logic [63:0] a, input logic [63:0] w1, input logic [63:0] w2);
        send(3'd1, a, w1, w2, 0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", 64'(cmd_ready), 64'd1, "ready after reset");
        check("R1", 64'(rsp_valid), 64'd0, "rsp_valid after reset");
        running = 1'b1;
        look(64'h0, 1'b0);

        cur_req = "R11";
        send(3'd4, 64'h40_0000_0000, 64'h8_0002, 64'h3000_0000_0000_0246, 4'd0, 0);
        look(64'h40_0000_3456, 1'b0);

        cur_req = "R2";
        ins(64'h1234_5678, 64'h0010_0001, 64'h1000_0000_0000_0010);
        look(64'h1234_4000, 0);
        look(64'h1234_7fff, 0);
        look(64'h1234_8000, 0);

        cur_req = "R3";
        ins(64'h5000_0000, 64'h1_0000_0000, 64'h1000_0000_0000_0002);
        look(64'h5000_0abc, 0);
        ins(64'h6000_0000, 64'h0ABC_DEF3, 64'h0);
        look(64'h6012_3450, 0);

        cur_req = "R4";
        ins(64'h7000_0000, 64'h2220, 64'h3A5B_0000_F234_5679);
        look(64'h7000_0010, 0);

        cur_req = "R5";
        ins(64'h40_0000_5000, 64'h3330, 64'h1000_0000_0000_0000);
        look(64'h40_0000_5004, 0);

        cur_req = "R7";
        ins(64'h1234_5000, 64'h4440, 64'h1000_0000_0000_0000);
        look(64'h1234_4000, 0);
        look(64'h1234_5008, 0);

        cur_req = "R8";
        for (int j = 0; j < 14; j++) ins(64'h8000_0000 + 64'(j) * 64'h1000, 64'(j) << 5, 64'(j) << 1);
        look(64'h8000_d000, 0);
        look(64'h8000_0000, 0);

        cur_req = "R9";
        send(3'd2, 64'h8000_0001 | 64'h8000_8000, 0, 0, 0, 0);
        look(64'h8000_9000, 0);
        look(64'h8000_c000, 0);
        ins(64'h9000_0000, 64'h5550, 0);

        cur_req = "R10";
        send(3'd3, 0, 0, 0, 0, 0);
        look(64'h40_0000_0000, 0);
        look(64'h9000_0000, 0);
        for (int j = 0; j < 13; j++) ins(64'hA000_0000 + 64'(j) * 64'h1000, 64'(j) << 6, 0);
        look(64'hA000_C000, 0);

        cur_req = "R6";
        look(64'hDEAD_0000, 1'b1);
        look(64'hDEAD_0000, 1'b0);

        cur_req = "R11";
        send(3'd4, 64'hB000_0000, 64'h10, 0, 4'd5, 0);
        send(3'd5, 0, 0, 0, 4'd9, 0);
        send(3'd6, 0, 0, 0, 0, 0);
        send(3'd5, 0, 0, 0, 4'd0, 0);
        look(64'h40_0000_0000, 0);

        cur_req = "R12";
        ins(64'hC000_0000, 64'h7770, 0);
        look(64'hC000_0000, 0);

        running = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule